// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave side of a four-wire serial link in SPI mode 0 in front of a small byte-wide memory. Here the memory is a 256-byte register array. The SPI pins are sampled by the system clock through synchronisers, so SCK must be well below the system clock rate. After chip select falls, the first eight bits form an instruction. The instruction can be one of these: a status read, a status write, an array read, an array write, or setting or clearing the write-enable latch.

Array writes collect up to 16 data bytes in a page buffer. The byte address counter wraps inside a 16-byte page. Nothing reaches the array unless chip select rises exactly on a data byte boundary. A committed write starts an internal cycle of `WR_CYCLES` system clocks. During that cycle the status register reports write-in-progress, and only status reads are served. A hold input freezes a transfer in the middle without losing its position.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, `so_oe` is low, the status register reads 0x00 and every array byte reads 0x00. An instruction is accepted only after a falling edge of `cs_n`.
- R2: The write-enable latch (status bit 1) is set by instruction 0x06. It is set only when `cs_n` rises right after exactly 8 instruction bits. One extra SCK rising edge before `cs_n` rises leaves the latch clear.
- R3: Instruction 0x02 is followed by an 8-bit address and then data bytes. It stores the data bytes at consecutive addresses. If the latch is clear, the instruction is ignored.
- R4: Inside a write, the address counter wraps from offset 15 of a 16-byte page back to offset 0 of the same page. A later byte overwrites an earlier one at the same offset.
- R5: A write (array or status) is committed only when `cs_n` rises after a whole number of data bytes, with at least one data byte. Otherwise nothing is written, no cycle starts and the latch keeps its value.
- R6: Status bit 0 reads 1 for `WR_CYCLES` clocks after a commit. Instruction 0x05 returns the status byte MSB first, and it works during the cycle.
- R7: Instruction 0x01 with a data byte stores only data bits 3 and 2 into status bits 3 and 2. The other status bits stay as defined by the other requirements.
- R8: Instruction 0x04 clears the latch. The end of any write cycle also clears the latch.
- R9: While a write cycle runs, every instruction other than 0x05 is ignored, even if the latch is set.
- R10: Instruction 0x03 with an 8-bit address streams bytes from sequential addresses. The stream wraps from 0xFF to 0x00 and continues until `cs_n` rises.
- R11: `hold_n` low pauses the transfer. The hold state changes only while SCK is low. While held, SCK and SI are ignored and `so_oe` is low. On release, the transfer continues where it stopped.
- R12: `so_oe` is high only during the output phase of a read, while selected and not held. SO changes only after a falling SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in, sampled on SCK rise |
| hold_n | input | 1 | Transfer pause, active low |
| so | output | 1 | Serial data out, updated after SCK fall |
| so_oe | output | 1 | Output enable for the SO pad driver |

## Verification
The assertions assume that SCK, SI, `cs_n` and `hold_n` stay stable for several system clocks around each edge. They also assume that `cs_n` never moves in the same synchronised cycle as SCK, and that `hold_n` only moves while SCK is low. The bench keeps within this. SCK has a half period of ten system clocks, SI is set five clocks before each rising edge, and `cs_n` changes only with SCK low and settled. Hold is applied and released only between bits with SCK low, and extra SCK pulses are sent only while held.

// File: rtl/eeprom_pkg.sv
// Package: shared opcodes and the transfer state type for the serial
// memory slave. Assumes single-byte instructions and single-byte addresses.
package eeprom_pkg;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,    // deselected
        ST_OPC,     // collecting instruction byte
        ST_ADDR,    // collecting address byte
        ST_WDATA,   // collecting array data bytes
        ST_SDATA,   // collecting status data byte
        ST_RDOUT,   // streaming output
        ST_ARMED,   // latch instruction complete, waiting for deselect
        ST_IGNORE   // rest of transfer discarded
    } xfer_st_t;
endpackage

// File: rtl/eeprom_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; reset value is chosen per bit.
module eeprom_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first flop takes the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= RST_VAL;
                else        chain[0] <= d;
            end
        end else begin : g_next
            // later flops resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eeprom_wcycle.sv
// Module: internal write cycle timer. A start pulse makes busy high for
// exactly CYCLES clocks, followed by a one-clock done pulse.
// Assumes start is never raised while busy.
module eeprom_wcycle #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // count the cycle length and flag its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R5
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/eeprom_array.sv
// Module: byte array with a one-page staging buffer. Bytes are staged
// by page offset and copied to the array in a single clock on commit.
// Assumes clr, stage_en and commit never coincide.
module eeprom_array #(
    parameter int AW = 8,
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stage_en,
    input  logic [OFF_W-1:0] stage_off,
    input  logic [7:0]       stage_data,
    input  logic             commit,
    input  logic [AW-OFF_W-1:0] page,
    input  logic [AW-1:0]    rd_addr,
    output logic [7:0]       rd_data
);
    localparam int DEPTH = 1 << AW;
    localparam int PAGE = 1 << OFF_W;

    logic [7:0] mem [DEPTH];
    logic [7:0] pbuf [PAGE];
    logic [PAGE-1:0] pvalid;

    // staging buffer: later bytes at the same offset overwrite earlier ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvalid <= '0;
            for (int j = 0; j < PAGE; j++) pbuf[j] <= 8'h00;
        end else if (clr) begin
            pvalid <= '0;
        end else if (stage_en) begin
            pvalid[stage_off] <= 1'b1;
            pbuf[stage_off]   <= stage_data;
        end
    end

    // array storage: copy every staged byte on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (commit) begin
            for (int j = 0; j < PAGE; j++)
                if (pvalid[j]) mem[{page, OFF_W'(j)}] <= pbuf[j];
        end
    end

    assign rd_data = mem[rd_addr];

    // R3
    stage_commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en |-> !commit);
endmodule

// File: rtl/spi_eeprom_slave.sv
// Module: SPI mode-0 slave for a byte-wide memory. It decodes
// instructions, keeps the write-enable latch and the protect bits, stages
// page writes and streams reads. Assumes SCK is far slower than clk and
// the address width is at most 8 bits (one address byte).
module spi_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFF_W = 4,
    parameter int WR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so,
    output logic so_oe
);
    localparam int PG_W = ADDR_W - OFF_W;

    logic cs_n_s, hold_n_s, sck_s, si_s;
    logic cs_d, sck_d, held;
    logic cs_fall, cs_rise, sck_rise, sck_fall, byte_done;
    xfer_st_t state;
    logic [2:0] bit_cnt, tx_idx;
    logic [6:0] shreg;
    logic [7:0] rx_byte, tx_buf, status, rd_data;
    logic [ADDR_W-1:0] rd_ptr, wr_ptr, rd_addr;
    logic is_rd, arm_set, has_data, tx_on, tx_rd, so_q;
    logic wel;
    logic [1:0] bp, sr_stage;
    logic busy, wdone, wr_commit, sr_commit, arm_commit, start;
    logic stage_en, clr;

    eeprom_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, hold_n, sck, si}),
        .q({cs_n_s, hold_n_s, sck_s, si_s})
    );

    eeprom_wcycle #(.CYCLES(WR_CYCLES)) u_wcyc (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(wdone)
    );

    eeprom_array #(.AW(ADDR_W), .OFF_W(OFF_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .stage_en(stage_en),
        .stage_off(wr_ptr[OFF_W-1:0]), .stage_data(rx_byte),
        .commit(wr_commit), .page(wr_ptr[ADDR_W-1:OFF_W]),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // edge detection on the synchronised pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_n_s;
            sck_d <= sck_s;
        end
    end

    // hold state may only change while SCK is low
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= 1'b0;
        else if (!sck_s) held <= !hold_n_s;
    end

    assign cs_fall   = cs_d & ~cs_n_s;
    assign cs_rise   = ~cs_d & cs_n_s;
    assign sck_rise  = sck_s & ~sck_d & ~cs_n_s & ~held & ~cs_fall;
    assign sck_fall  = ~sck_s & sck_d & ~cs_n_s & ~held & ~cs_fall;
    assign rx_byte   = {shreg, si_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);
    assign status    = {4'b0000, bp, wel, busy};
    assign rd_addr   = (state == ST_ADDR) ? rx_byte[ADDR_W-1:0] : rd_ptr;

    assign arm_commit = cs_rise && (state == ST_ARMED) && (bit_cnt == 3'd0);
    assign wr_commit  = cs_rise && (state == ST_WDATA) && (bit_cnt == 3'd0) && has_data;
    assign sr_commit  = cs_rise && (state == ST_SDATA) && (bit_cnt == 3'd0) && has_data;
    assign start      = wr_commit | sr_commit;
    assign stage_en   = byte_done && (state == ST_WDATA);
    assign clr        = byte_done && (state == ST_ADDR) && !is_rd;

    // transfer sequencer: instruction decode, address, data and output shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            is_rd    <= 1'b0;
            arm_set  <= 1'b0;
            has_data <= 1'b0;
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            sr_stage <= '0;
            bp       <= '0;
            tx_buf   <= '0;
            tx_idx   <= '0;
            tx_on    <= 1'b0;
            tx_rd    <= 1'b0;
            so_q     <= 1'b0;
        end else if (cs_fall) begin
            state    <= ST_OPC;
            bit_cnt  <= '0;
            has_data <= 1'b0;
            tx_on    <= 1'b0;
        end else if (cs_rise) begin
            state <= ST_IDLE;
            tx_on <= 1'b0;
            if (sr_commit) bp <= sr_stage;
        end else if (sck_rise) begin
            shreg   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (state == ST_ARMED) begin
                state <= ST_IGNORE;
            end else if (bit_cnt == 3'd7) begin
                case (state)
                    ST_OPC: begin
                        if (rx_byte == OP_RDSR) begin
                            state  <= ST_RDOUT;
                            tx_buf <= status;
                            tx_idx <= '0;
                            tx_on  <= 1'b1;
                            tx_rd  <= 1'b0;
                        end else if (busy) begin
                            state <= ST_IGNORE;
                        end else begin
                            case (rx_byte)
                                OP_WREN: begin state <= ST_ARMED; arm_set <= 1'b1; end
                                OP_WRDI: begin state <= ST_ARMED; arm_set <= 1'b0; end
                                OP_READ: begin state <= ST_ADDR; is_rd <= 1'b1; end
                                OP_WRITE: begin
                                    state <= wel ? ST_ADDR : ST_IGNORE;
                                    is_rd <= 1'b0;
                                end
                                OP_WRSR: state <= wel ? ST_SDATA : ST_IGNORE;
                                default: state <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        if (is_rd) begin
                            state  <= ST_RDOUT;
                            tx_buf <= rd_data;
                            rd_ptr <= rx_byte[ADDR_W-1:0] + ADDR_W'(1);
                            tx_idx <= '0;
                            tx_on  <= 1'b1;
                            tx_rd  <= 1'b1;
                        end else begin
                            state  <= ST_WDATA;
                            wr_ptr <= rx_byte[ADDR_W-1:0];
                        end
                    end
                    ST_WDATA: begin
                        wr_ptr   <= {wr_ptr[ADDR_W-1:OFF_W], wr_ptr[OFF_W-1:0] + 1'b1};
                        has_data <= 1'b1;
                    end
                    ST_SDATA: begin
                        sr_stage <= rx_byte[3:2];
                        has_data <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (sck_fall && tx_on) begin
            so_q   <= tx_buf[3'd7 - tx_idx];
            tx_idx <= tx_idx + 1'b1;
            if (tx_idx == 3'd7) begin
                if (tx_rd) begin
                    tx_buf <= rd_data;
                    rd_ptr <= rd_ptr + ADDR_W'(1);
                end else begin
                    tx_buf <= status;
                end
            end
        end
    end

    // write-enable latch: cleared by cycle end, set or cleared by armed instruction
    always_ff @(posedge clk) begin
        if (!rst_n)          wel <= 1'b0;
        else if (wdone)      wel <= 1'b0;
        else if (arm_commit) wel <= arm_set;
    end

    assign so    = so_q;
    assign so_oe = !cs_n_s && tx_on && !held;

    // R2
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise && state == ST_ARMED));
    // R5
    cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));
    // R9
    busy_no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wel) |=> !wel);
    // R7
    bp_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $past(sr_commit));
    // R11
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held) |-> !$past(sck_s));
    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held) && !cs_fall && !cs_rise) |-> $stable(bit_cnt));
    // R12
    so_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_q) |-> $past(sck_fall));
endmodule

// File: tb/spi_eeprom_slave_tb.sv
// Bench: behavioural memory/status model driven by SPI tasks, plus a
// per-clock output-enable monitor.
module spi_eeprom_slave_tb;
    localparam int WRC = 2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    int errors = 0, checks = 0;
    bit finished = 0;

    logic [7:0] mm [256];
    logic [1:0] m_bp = 2'b00;
    logic m_wel = 1'b0;

    spi_eeprom_slave #(.ADDR_W(8), .OFF_W(4), .WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .so(so), .so_oe(so_oe)
    );

    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // per-clock model of the output enable (R12, R1, R11)
    int hi_cnt = 0, hold_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            hi_cnt   = cs_n ? hi_cnt + 1 : 0;
            hold_cnt = !hold_n ? hold_cnt + 1 : 0;
            if (hi_cnt >= 4 || hold_cnt >= 4) check("R12 so_oe idle", so_oe, 1'b0);
        end
    end

    task automatic xbit(input logic b, output logic r);
        si = b;
        tick(5);
        r = so;
        sck = 1'b1;
        tick(10);
        sck = 1'b0;
        tick(5);
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) xbit(t[i], r[i]);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        tick(10);
    endtask

    task automatic cs_hi();
        tick(5);
        cs_n = 1'b1;
        tick(20);
    endtask

    task automatic op_only(input logic [7:0] op);
        logic [7:0] d;
        cs_lo(); xbyte(op, d); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] d;
        cs_lo(); xbyte(8'h05, d); xbyte(8'h00, st); cs_hi();
    endtask

    task automatic rd1(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] d;
        cs_lo(); xbyte(8'h03, d); xbyte(a, d); xbyte(8'h00, v); cs_hi();
    endtask

    task automatic wait_cycle();
        tick(WRC + 100);
    endtask

    initial begin
        logic [7:0] v, d;
        logic b;
        for (int i = 0; i < 256; i++) mm[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        check("R1 so_oe after reset", so_oe, 1'b0);
        rdsr(v); check("R1 status after reset", v, 8'h00);
        rd1(8'h00, v); check("R1 array after reset", v, mm[0]);

        // R3 write without latch ignored
        cs_lo(); xbyte(8'h02, d); xbyte(8'h10, d); xbyte(8'hAA, d); cs_hi();
        rdsr(v); check("R3 no cycle without latch", v, 8'h00);
        rd1(8'h10, v); check("R3 write without latch ignored", v, mm[8'h10]);

        // R2 extra clock after enable leaves latch clear
        cs_lo(); xbyte(8'h06, d); xbit(1'b0, b); cs_hi();
        rdsr(v); check("R2 nine-bit enable", v, 8'h00);
        op_only(8'h06); m_wel = 1'b1;
        rdsr(v); check("R2 enable sets bit1", v, {4'b0, m_bp, m_wel, 1'b0});

        // R3 R6 R8 byte stream write
        cs_lo(); xbyte(8'h02, d); xbyte(8'h20, d);
        xbyte(8'h11, d); xbyte(8'h22, d); xbyte(8'h33, d); cs_hi();
        mm[8'h20] = 8'h11; mm[8'h21] = 8'h22; mm[8'h22] = 8'h33;
        rdsr(v); check("R6 wip during cycle", v, {4'b0, m_bp, m_wel, 1'b1});
        wait_cycle(); m_wel = 1'b0;
        rdsr(v); check("R8 latch cleared after cycle", v, {4'b0, m_bp, m_wel, 1'b0});
        for (int i = 0; i < 3; i++) begin
            rd1(8'h20 + 8'(i), v); check("R3 written byte", v, mm[8'h20 + i]);
        end

        // R5 abort mid byte and abort after address
        op_only(8'h06); m_wel = 1'b1;
        cs_lo(); xbyte(8'h02, d); xbyte(8'h50, d); xbyte(8'h77, d);
        for (int i = 0; i < 4; i++) xbit(1'b1, b);
        cs_hi();
        rdsr(v); check("R5 mid-byte rise discards", v, {4'b0, m_bp, m_wel, 1'b0});
        cs_lo(); xbyte(8'h02, d); xbyte(8'h50, d); cs_hi();
        rdsr(v); check("R5 no data byte discards", v, {4'b0, m_bp, m_wel, 1'b0});
        rd1(8'h50, v); check("R5 array unchanged", v, mm[8'h50]);
        op_only(8'h04); m_wel = 1'b0;
        rdsr(v); check("R8 disable clears latch", v, {4'b0, m_bp, m_wel, 1'b0});

        // R4 page wrap with overwrite
        op_only(8'h06);
        cs_lo(); xbyte(8'h02, d); xbyte(8'h3E, d);
        for (int k = 0; k < 18; k++) begin
            xbyte(8'(k + 1), d);
            mm[{4'h3, 4'(4'hE + k)}] = 8'(k + 1);
        end
        cs_hi();
        wait_cycle();
        cs_lo(); xbyte(8'h03, d); xbyte(8'h30, d);
        for (int k = 0; k < 16; k++) begin
            xbyte(8'h00, v); check("R4 page wrap", v, mm[8'h30 + k]);
        end
        cs_hi();

        // R7 R6 status write
        op_only(8'h06); m_wel = 1'b1;
        cs_lo(); xbyte(8'h01, d); xbyte(8'hFF, d); cs_hi();
        m_bp = 2'b11;
        rdsr(v); check("R6 status readable in cycle", v, {4'b0, m_bp, m_wel, 1'b1});
        wait_cycle(); m_wel = 1'b0;
        rdsr(v); check("R7 only bits 3:2 stored", v, 8'h0C);

        // R9 instructions during busy ignored
        op_only(8'h06); m_wel = 1'b1;
        cs_lo(); xbyte(8'h02, d); xbyte(8'h60, d); xbyte(8'h5A, d); cs_hi();
        mm[8'h60] = 8'h5A;
        cs_lo(); xbyte(8'h02, d); xbyte(8'h61, d); xbyte(8'hA5, d); cs_hi();
        cs_lo(); xbyte(8'h01, d); xbyte(8'h00, d); cs_hi();
        wait_cycle(); m_wel = 1'b0;
        rdsr(v); check("R9 status write ignored while busy", v, {4'b0, m_bp, m_wel, 1'b0});
        rd1(8'h61, v); check("R9 array write ignored while busy", v, mm[8'h61]);
        rd1(8'h60, v); check("R3 byte before busy", v, mm[8'h60]);

        // R10 read wraps across top of array
        op_only(8'h06);
        cs_lo(); xbyte(8'h02, d); xbyte(8'hFF, d); xbyte(8'hC3, d); cs_hi();
        mm[8'hFF] = 8'hC3; wait_cycle();
        op_only(8'h06);
        cs_lo(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h3C, d); cs_hi();
        mm[8'h00] = 8'h3C; wait_cycle();
        cs_lo(); xbyte(8'h03, d); xbyte(8'hFE, d);
        xbyte(8'h00, v); check("R10 read FE", v, mm[8'hFE]);
        xbyte(8'h00, v); check("R10 read FF", v, mm[8'hFF]);
        xbyte(8'h00, v); check("R10 wrap to 00", v, mm[8'h00]);
        cs_hi();

        // R11 hold in the middle of a read byte
        cs_lo(); xbyte(8'h03, d); xbyte(8'h20, d);
        for (int i = 7; i >= 5; i--) xbit(1'b0, v[i]);
        hold_n = 1'b0; tick(10);
        check("R11 so_oe low while held", so_oe, 1'b0);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; sck = 1'b1; tick(10); sck = 1'b0; tick(10);
        end
        hold_n = 1'b1; tick(10);
        check("R11 so_oe back after release", so_oe, 1'b1);
        for (int i = 4; i >= 0; i--) xbit(1'b0, v[i]);
        check("R11 byte intact across hold", v, mm[8'h20]);
        xbyte(8'h00, v); check("R11 stream continues", v, mm[8'h21]);
        cs_hi();

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule